// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block keeps a DDR SDRAM's cells refreshed. An interval timer runs freely and ticks once every `REFI_CYCLES` clocks, which is one average refresh period. Each tick adds one unit to a refresh debt. While the debt is nonzero, the block asks the command arbiter for a slot. When the arbiter grants the slot, the block drives a one-cycle auto-refresh command onto the command pins. It then holds `busy_o` high for the refresh recovery time, so that the arbiter issues nothing else in that window.

The debt lets the arbiter put off refreshes while it is serving traffic. When the debt reaches `MAX_DEBT`, an urgent flag tells the arbiter that it must grant at once. A self-refresh request goes through the same request/grant handshake. The grant enters self refresh by issuing the refresh encoding with clock enable going low in the same cycle. Dropping the request raises clock enable again. A guard window of `SR_EXIT_CYCLES` clocks then follows, and `busy_o` stays high throughout it. During self refresh the interval timer is held at zero and the debt is cleared. Precharging the banks before a refresh is the arbiter's task.

Top module: `ddr_refresh_sched`

## Requirements
- R1: The interval timer advances on every clock outside self refresh and the exit guard, and adds one to the debt every `REFI_CYCLES` clocks. `ref_req_o` is high in idle whenever the debt is nonzero.
- R2: If `ref_req_o` and `ref_gnt_i` are both high at a clock edge, the next cycle carries the refresh encoding {cs_n,ras_n,cas_n,we_n}=0001 for exactly one cycle. Every other cycle carries the no-operation encoding 0111.
- R3: A grant seen while `ref_req_o` is low has no effect: the command stays at 0111, `busy_o` stays low and clock enable stays high.
- R4: `busy_o` is high for exactly `TRFC_CYCLES` cycles, beginning with the refresh command cycle. `ref_req_o` is low for the whole of that window.
- R5: The debt saturates at `MAX_DEBT`. `ref_urgent_o` is high exactly when the debt equals `MAX_DEBT`. Each granted refresh lowers the debt by one, and the request stays up while debt remains.
- R6: In idle, `sr_req_i` raises `ref_req_o`. On the grant, `cke_o` falls in the same cycle as the 0001 encoding, and the debt is cleared.
- R7: While self refresh is held, `cke_o` stays low and `ref_req_o` stays low. The interval timer does not advance and restarts from zero after the exit guard.
- R8: When `sr_req_i` is low during self refresh, `cke_o` rises at the next edge. `busy_o` is then high for exactly `SR_EXIT_CYCLES` cycles, during which no request is raised.
- R9: While `rst_ni` is low: command 0111, `cke_o` high, `ref_req_o`, `ref_urgent_o` and `busy_o` low, debt and timer zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_gnt_i | input | 1 | Arbiter grant for the pending refresh or self-refresh entry |
| sr_req_i | input | 1 | Request to enter and stay in self refresh |
| ref_req_o | output | 1 | Refresh or self-refresh entry slot requested |
| ref_urgent_o | output | 1 | Debt at maximum, grant required now |
| busy_o | output | 1 | Other commands blocked (refresh recovery or exit guard) |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
`ref_req_o` and `ref_urgent_o` change in the same cycle as the debt register. They are therefore due at the negative edge that follows the `REFI_CYCLES`-th rising edge after the timer last started from zero. The command pins, `cke_o` and `busy_o` are registered once, so they change one edge after the cycle in which the grant or the falling `sr_req_i` is seen. Each vector in the bench applies its inputs for a stated number of rising edges and samples at the following negative edge. The edge counts were worked out by hand from these latencies, using short bench parameters, so every check lands on the first or last cycle of a window.

// File: rtl/ddr_refresh_pkg.sv
package ddr_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RFC  = 2'd1,
    ST_SR   = 2'd2,
    ST_EXIT = 2'd3
  } rs_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;
endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int unsigned REFI_CYCLES = 2080
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (REFI_CYCLES > 1) ? $clog2(REFI_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFI_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (run_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_debt.sv
module ref_debt #(
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          clr_i,
  output logic [DW-1:0] debt_o,
  output logic          pend_o,
  output logic          urgent_o
);
  localparam logic [DW-1:0] MAXV = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else if (clr_i) begin
      debt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (debt_q != MAXV) debt_q <= debt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (debt_q != '0) debt_q <= debt_q - 1'b1;
    end
  end

  assign debt_o   = debt_q;
  assign pend_o   = (debt_q != '0);
  assign urgent_o = (debt_q == MAXV);
endmodule

// File: rtl/ref_seq.sv
module ref_seq
  import ddr_refresh_pkg::*;
#(
  parameter int unsigned TRFC_CYCLES    = 10,
  parameter int unsigned SR_EXIT_CYCLES = 200
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pend_i,
  input  logic      sr_req_i,
  input  logic      gnt_i,
  output rs_state_e state_o,
  output logic      rf_take_o,
  output logic      sr_enter_o,
  output logic      req_o,
  output logic      busy_o,
  output logic      cke_o,
  output logic [3:0] cmd_o
);
  localparam int unsigned WMAX = (TRFC_CYCLES > SR_EXIT_CYCLES) ? TRFC_CYCLES : SR_EXIT_CYCLES;
  localparam int unsigned WW   = (WMAX > 1) ? $clog2(WMAX) : 1;
  localparam logic [WW-1:0] RFC_LOAD  = WW'(TRFC_CYCLES - 1);
  localparam logic [WW-1:0] EXIT_LOAD = WW'(SR_EXIT_CYCLES - 1);

  rs_state_e     state_q;
  logic [WW-1:0] win_q;
  logic          cke_q;
  logic [3:0]    cmd_q;
  logic          accept;

  assign req_o      = (state_q == ST_IDLE) && (pend_i || sr_req_i);
  assign accept     = req_o && gnt_i;
  assign sr_enter_o = accept && sr_req_i;
  assign rf_take_o  = accept && !sr_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      cke_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
    end else begin
      cmd_q <= accept ? CMD_REF : CMD_NOP;
      unique case (state_q)
        ST_IDLE: begin
          if (sr_enter_o) begin
            state_q <= ST_SR;
            cke_q   <= 1'b0;
          end else if (rf_take_o) begin
            state_q <= ST_RFC;
            win_q   <= RFC_LOAD;
          end
        end
        ST_RFC: begin
          if (win_q == '0) state_q <= ST_IDLE;
          else             win_q   <= win_q - 1'b1;
        end
        ST_SR: begin
          if (!sr_req_i) begin
            state_q <= ST_EXIT;
            win_q   <= EXIT_LOAD;
            cke_q   <= 1'b1;
          end
        end
        ST_EXIT: begin
          if (win_q == '0) state_q <= ST_IDLE;
          else             win_q   <= win_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q == ST_RFC) || (state_q == ST_EXIT);
  assign cke_o   = cke_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import ddr_refresh_pkg::*;
#(
  parameter int unsigned REFI_CYCLES    = 2080,
  parameter int unsigned TRFC_CYCLES    = 10,
  parameter int unsigned SR_EXIT_CYCLES = 200,
  parameter int unsigned MAX_DEBT       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  input  logic sr_req_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic busy_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);

  rs_state_e     state;
  logic          tick, run, pend, rf_take, sr_enter;
  logic [DW-1:0] debt;
  logic [3:0]    cmd;

  // timer frozen in self refresh and during the exit guard
  assign run = (state == ST_IDLE) || (state == ST_RFC);

  refi_timer #(.REFI_CYCLES(REFI_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (sr_enter),
    .tick_o (tick)
  );

  ref_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .dec_i    (rf_take),
    .clr_i    (sr_enter),
    .debt_o   (debt),
    .pend_o   (pend),
    .urgent_o (ref_urgent_o)
  );

  ref_seq #(
    .TRFC_CYCLES    (TRFC_CYCLES),
    .SR_EXIT_CYCLES (SR_EXIT_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .sr_req_i   (sr_req_i),
    .gnt_i      (ref_gnt_i),
    .state_o    (state),
    .rf_take_o  (rf_take),
    .sr_enter_o (sr_enter),
    .req_o      (ref_req_o),
    .busy_o     (busy_o),
    .cke_o      (cke_o),
    .cmd_o      (cmd)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

  logic unused_debt;
  assign unused_debt = ^debt;
endmodule

// File: rtl/ddr_refresh_sched_chk.sv
module ddr_refresh_sched_chk #(
  parameter int unsigned TRFC_CYCLES    = 10,
  parameter int unsigned SR_EXIT_CYCLES = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_gnt_i,
  input logic sr_req_i,
  input logic ref_req_o,
  input logic busy_o,
  input logic cke_o,
  input logic cs_n_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o
);
  localparam int unsigned LIM = (TRFC_CYCLES > SR_EXIT_CYCLES) ? TRFC_CYCLES : SR_EXIT_CYCLES;
  localparam int unsigned RW  = $clog2(LIM + 2);

  logic ref_cmd;
  logic [RW-1:0] run_q;
  assign ref_cmd = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (!busy_o)                run_q <= '0;
    else if (run_q != RW'(LIM + 1))  run_q <= run_q + 1'b1;
  end

  AST_REF_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd |-> $past(ref_req_o && ref_gnt_i)); // R2
  AST_REF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd |=> !ref_cmd); // R2
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ref_req_o); // R4
  AST_BUSY_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cmd && cke_o) |-> busy_o); // R4
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(LIM)); // R4
  AST_CKE_FALL_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (ref_cmd && $past(sr_req_i))); // R6
  AST_NO_REQ_IN_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !ref_req_o); // R7
  AST_EXIT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (busy_o && !$past(sr_req_i))); // R8
endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk #(
  .TRFC_CYCLES    (TRFC_CYCLES),
  .SR_EXIT_CYCLES (SR_EXIT_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_gnt_i (ref_gnt_i),
  .sr_req_i  (sr_req_i),
  .ref_req_o (ref_req_o),
  .busy_o    (busy_o),
  .cke_o     (cke_o),
  .cs_n_o    (cs_n_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .we_n_o    (we_n_o)
);

// File: tb/ddr_refresh_sched_tb.sv
module ddr_refresh_sched_tb;
  localparam int unsigned REFI = 16;
  localparam int unsigned TRFC = 4;
  localparam int unsigned SREX = 6;
  localparam int unsigned MAXD = 3;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;
  localparam int NV = 20;

  // {gnt, sr, edges[7:0], req, urg, busy, cke, cmd[3:0], tag[15:0]}
  typedef logic [33:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {1'b0,1'b0,8'd15, 1'b0,1'b0,1'b0,1'b1, NOP, "R1"},
    {1'b0,1'b0,8'd1,  1'b1,1'b0,1'b0,1'b1, NOP, "R1"},
    {1'b1,1'b0,8'd1,  1'b0,1'b0,1'b1,1'b1, REF, "R2"},
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b1,1'b1, NOP, "R4"},
    {1'b0,1'b0,8'd2,  1'b0,1'b0,1'b1,1'b1, NOP, "R4"},
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b0,1'b1, NOP, "R4"},
    {1'b0,1'b0,8'd10, 1'b0,1'b0,1'b0,1'b1, NOP, "R1"},
    {1'b0,1'b0,8'd1,  1'b1,1'b0,1'b0,1'b1, NOP, "R1"},
    {1'b0,1'b0,8'd16, 1'b1,1'b0,1'b0,1'b1, NOP, "R5"},
    {1'b0,1'b0,8'd16, 1'b1,1'b1,1'b0,1'b1, NOP, "R5"},
    {1'b0,1'b0,8'd16, 1'b1,1'b1,1'b0,1'b1, NOP, "R5"},
    {1'b1,1'b0,8'd1,  1'b0,1'b0,1'b1,1'b1, REF, "R5"},
    {1'b0,1'b0,8'd4,  1'b1,1'b0,1'b0,1'b1, NOP, "R5"},
    {1'b1,1'b1,8'd1,  1'b0,1'b0,1'b0,1'b0, REF, "R6"},
    {1'b0,1'b1,8'd40, 1'b0,1'b0,1'b0,1'b0, NOP, "R7"},
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b1,1'b1, NOP, "R8"},
    {1'b0,1'b0,8'd5,  1'b0,1'b0,1'b1,1'b1, NOP, "R8"},
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b0,1'b1, NOP, "R8"},
    {1'b1,1'b0,8'd15, 1'b0,1'b0,1'b0,1'b1, NOP, "R3"},
    {1'b0,1'b0,8'd1,  1'b1,1'b0,1'b0,1'b1, NOP, "R7"}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0, sr = 1'b0;
  logic req, urg, busy, cke, cs_n, ras_n, cas_n, we_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_refresh_sched #(
    .REFI_CYCLES(REFI), .TRFC_CYCLES(TRFC), .SR_EXIT_CYCLES(SREX), .MAX_DEBT(MAXD)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt), .sr_req_i(sr),
    .ref_req_o(req), .ref_urgent_o(urg), .busy_o(busy), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  task automatic chk(input logic [15:0] tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input logic [15:0] tag, input logic e_req, input logic e_urg,
                         input logic e_busy, input logic e_cke, input logic [3:0] e_cmd);
    chk(tag, "ref_req", int'(req), int'(e_req));
    chk(tag, "urgent", int'(urg), int'(e_urg));
    chk(tag, "busy", int'(busy), int'(e_busy));
    chk(tag, "cke", int'(cke), int'(e_cke));
    chk(tag, "cmd", int'({cs_n, ras_n, cas_n, we_n}), int'(e_cmd));
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b1, NOP); // held in reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      gnt = VEC[i][33];
      sr  = VEC[i][32];
      step(int'(VEC[i][31:24]));
      chk_all(VEC[i][15:0], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:16]);
    end
    // R9: reset mid-run clears a pending request at once
    gnt = 1'b0;
    sr  = 1'b0;
    step(3);
    rst_n = 1'b0;
    #1;
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b1, NOP);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: timer restarts from zero after reset
    step(REFI - 1);
    chk("R1", "ref_req before interval", int'(req), 0);
    step(1);
    chk("R1", "ref_req at interval", int'(req), 1);
    // R6: self-refresh request alone raises the request with zero debt
    gnt = 1'b1;
    step(1); // consumes the refresh debt
    gnt = 1'b0;
    step(TRFC);
    chk("R4", "back to idle", int'(busy), 0);
    sr = 1'b1;
    #1;
    chk("R6", "ref_req from sr_req", int'(req), 1);
    gnt = 1'b1;
    step(1);
    chk("R6", "cke low on entry", int'(cke), 0);
    gnt = 1'b0;
    step(1);
    chk("R2", "cmd single cycle", int'({cs_n, ras_n, cas_n, we_n}), int'(NOP));
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule